// File: doc/BRIEF.md
# Wake Event Latch Unit

This block watches two banks of wake sources: one for on-chip peripheral lines and one for external pins. Each bank has its own enable mask and its own per-bit edge direction. It also keeps a sticky record of every qualifying transition. Each source line passes through a two-stage synchronizer and then an edge detector. A transition in the chosen direction sets a sticky pending bit. The bit stays set until software writes a one to it.

A pending bit drives the wake request only when its enable bit is also set. The wake request is the OR across both banks. Software uses a simple synchronous register port to set up the enables and edge directions and to clear pending events. The usual clear is to read the pending word and write the same value back.

Top module: `wake_latch_unit`

## Requirements
- R1: After reset, both enable registers read 0, the pin bank edge register reads 0, the internal bank edge register reads the parameter `INT_POL_RST` (default 0x00000034: bits 2, 4 and 5 rising), both pending registers read 0, and `wake_req` is 0.
- R2: When a source's edge bit is 1, a 0-to-1 transition on that source sets its pending bit.
- R3: When a source's edge bit is 0, a 1-to-0 transition sets its pending bit. A transition in the other direction leaves the pending bit unchanged.
- R4: A pending bit latches even when its enable bit is 0, and in that case it does not raise `wake_req`.
- R5: The masked register reads as the bitwise AND of pending and enable. `wake_req` is 1 when either bank has a nonzero masked value, and it stays 1 until the pending bits are cleared.
- R6: Writing the pending register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: A clear write and a newly detected edge on the same bit in the same cycle leave that bit set. Other bits in the same write are still cleared.
- R8: The byte address selects the register. Bit 4 selects the bank (0 internal, 1 pin). Bits 3:2 select enable (0), edge direction (1), pending (2) or masked (3). Enable and edge direction are read/write. Writes to the masked address have no effect, and the two banks are independent.
- R9: An input change is reflected in the pending register after the third rising clock edge that follows it. It is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| src_int | input | 32 | Internal peripheral wake sources, asynchronous |
| src_pin | input | 32 | External pin wake sources, asynchronous |
| wake_req | output | 1 | Wake request to the power controller |

## Verification
A software clear of a pending bit and a fresh edge on the same bit can meet in one clock. When they do, the edge must survive. The bench provokes this by driving a falling pin transition and then timing the clear write to land on the third rising edge after the change, the cycle in which the detector fires. In the same write it also clears a different, already pending bit. It then judges the result by reading the pending word: the colliding bit must still be set and the other bit must be gone.

// File: rtl/wlu_pkg.sv
// Package: shared address decode constants for the wake event latch unit.
// Assumes byte addressing with 32-bit registers.
package wlu_pkg;
    localparam int ADDR_W    = 5;
    localparam int BANK_BIT  = 4;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_EDGE   = 2'd1,
        SEL_PEND   = 2'd2,
        SEL_MASKED = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wlu_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes every bit is an independent level; no bus coherency is implied.
module wlu_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wlu_edge.sv
// Module: per-bit edge detector with a selectable direction.
// Assumes lvl_i is already synchronous. pol_i=1 picks rising, 0 picks falling.
module wlu_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign hit_o[b] = pol_i[b] ? ( lvl_i[b] & ~prev_q[b])
                                   : (~lvl_i[b] &  prev_q[b]);
    end
endmodule

// File: rtl/wlu_group.sv
// Module: one wake bank (enable, edge direction, sticky pending bits).
// Assumes the write strobes are one-hot, one cycle each, decoded by the parent.
module wlu_group #(
    parameter int           W       = 32,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] POL_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         en_we,
    input  logic         pol_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] lvl;
    logic [W-1:0] en_q, pol_q, pend_q;
    logic [W-1:0] clr_mask;

    wlu_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src_i), .sync_o(lvl)
    );

    wlu_edge #(.W(W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .pol_i(pol_q), .hit_o(hit_o)
    );

    assign clr_mask = clr_we ? wdata_i : '0;

    // Software-owned configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= POL_RST;
        end else begin
            if (en_we)  en_q  <= wdata_i;
            if (pol_we) pol_q <= wdata_i;
        end
    end

    // Sticky pending bits: a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | hit_o;
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign pend_o = pend_q;

    AST_UNCLEARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(pend_q & ~clr_mask)) == $past(pend_q & ~clr_mask))); // R6
    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(hit_o)) == $past(hit_o))); // R7
    AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit_o)) == '0)); // R2
endmodule

// File: rtl/wake_latch_unit.sv
// Module: top of the wake event latch unit. Decodes the register port,
// holds an internal-source bank and a pin bank, and raises wake_req.
// Assumes a single-cycle write strobe and a combinational read.
module wake_latch_unit #(
    parameter int           W           = 32,
    parameter int           STAGES      = 2,
    parameter logic [W-1:0] INT_POL_RST = 32'h0000_0034
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [wlu_pkg::ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]              reg_wdata,
    output logic [W-1:0]              reg_rdata,
    input  logic [W-1:0]              src_int,
    input  logic [W-1:0]              src_pin,
    output logic                      wake_req
);
    import wlu_pkg::*;

    localparam int NBANK = 2;

    reg_sel_e     sel;
    logic [W-1:0] src_b   [NBANK];
    logic [W-1:0] en_b    [NBANK];
    logic [W-1:0] pol_b   [NBANK];
    logic [W-1:0] pend_b  [NBANK];
    logic [W-1:0] hit_b   [NBANK];
    logic [W-1:0] mask_b  [NBANK];
    logic [NBANK-1:0] bank_hit_any;
    logic [NBANK-1:0] bank_wake;

    assign sel      = reg_sel_e'(reg_addr[3:2]);
    assign src_b[0] = src_int;
    assign src_b[1] = src_pin;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        localparam logic [W-1:0] PRST = (g == 0) ? INT_POL_RST : '0;
        logic hit_me;
        assign hit_me = reg_wr && (reg_addr[BANK_BIT] == g[0]);

        wlu_group #(.W(W), .STAGES(STAGES), .POL_RST(PRST)) u_grp (
            .clk(clk), .rst_n(rst_n), .src_i(src_b[g]),
            .en_we(hit_me && sel == SEL_ENABLE),
            .pol_we(hit_me && sel == SEL_EDGE),
            .clr_we(hit_me && sel == SEL_PEND),
            .wdata_i(reg_wdata),
            .en_o(en_b[g]), .pol_o(pol_b[g]), .pend_o(pend_b[g]), .hit_o(hit_b[g])
        );

        assign mask_b[g]       = pend_b[g] & en_b[g];
        assign bank_wake[g]    = |mask_b[g];
        assign bank_hit_any[g] = |hit_b[g];
    end

    assign wake_req = |bank_wake;

    // Read mux: bank by address bit 4, register by bits 3:2.
    always_comb begin
        logic bk;
        bk = reg_addr[BANK_BIT];
        case (sel)
            SEL_ENABLE: reg_rdata = en_b[bk];
            SEL_EDGE:   reg_rdata = pol_b[bk];
            SEL_PEND:   reg_rdata = pend_b[bk];
            default:    reg_rdata = mask_b[bk];
        endcase
    end

    AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> ($past(reg_wr) || $past(|bank_hit_any))); // R5
    AST_WAKE_NEEDS_WRITE_TO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_req) |-> $past(reg_wr)); // R5
endmodule

// File: tb/sim_wake_latch_unit.sv
module sim_wake_latch_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_int = '0;
    logic [31:0] src_pin = '0;
    logic        wake_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam logic [4:0] A_IEN = 5'h00, A_IPOL = 5'h04, A_IPEND = 5'h08, A_IMSK = 5'h0C;
    localparam logic [4:0] A_PEN = 5'h10, A_PPOL = 5'h14, A_PPEND = 5'h18, A_PMSK = 5'h1C;

    always #4 clk = ~clk;

    wake_latch_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_int(src_int),
        .src_pin(src_pin), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        logic [31:0] v;
        rd(A_IPEND, v); wr(A_IPEND, v);
        rd(A_PPEND, v); wr(A_PPEND, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_IEN, v);   chk("R1 int enable", v, 32'h0);
        rd(A_PEN, v);   chk("R1 pin enable", v, 32'h0);
        rd(A_IPOL, v);  chk("R1 int edge", v, 32'h0000_0034);
        rd(A_PPOL, v);  chk("R1 pin edge", v, 32'h0);
        rd(A_IPEND, v); chk("R1 int pending", v, 32'h0);
        rd(A_PPEND, v); chk("R1 pin pending", v, 32'h0);
        chk("R1 wake", {31'b0, wake_req}, 32'h0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        src_int[2] = 1; settle();
        rd(A_IPEND, v); chk("R2 rising latched", v, 32'h4);
        clear_all();
        src_int[2] = 0; settle();
        rd(A_IPEND, v); chk("R3 falling ignored on rising bit", v, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        src_pin[7] = 1; settle();
        rd(A_PPEND, v); chk("R3 rising ignored on falling pin", v, 32'h0);
        src_pin[7] = 0; settle();
        rd(A_PPEND, v); chk("R3 falling latched", v, 32'h80);
    endtask

    task automatic t_disabled_and_mask();
        logic [31:0] v;
        chk("R4 no wake while disabled", {31'b0, wake_req}, 32'h0);
        rd(A_PMSK, v); chk("R4 masked zero while disabled", v, 32'h0);
        wr(A_PEN, 32'h0000_0081);
        rd(A_PMSK, v); chk("R5 masked = pend & enable", v, 32'h80);
        repeat (10) @(negedge clk);
        chk("R5 wake held", {31'b0, wake_req}, 32'h1);
        rd(A_PPEND, v); wr(A_PPEND, v);
        rd(A_PPEND, v); chk("R6 write-back clears", v, 32'h0);
        chk("R5 wake drops after clear", {31'b0, wake_req}, 32'h0);
        wr(A_PEN, 32'h0);
    endtask

    task automatic t_partial_clear();
        logic [31:0] v;
        src_int[4] = 1; src_int[5] = 1; settle();
        rd(A_IPEND, v); chk("R2 two rising bits", v, 32'h30);
        wr(A_IPEND, 32'h10);
        rd(A_IPEND, v); chk("R6 zero bits kept", v, 32'h20);
        wr(A_IEN, 32'h20);
        chk("R5 internal bank raises wake", {31'b0, wake_req}, 32'h1);
        wr(A_IPEND, 32'h20);
        chk("R5 wake low after clear", {31'b0, wake_req}, 32'h0);
        wr(A_IEN, 32'h0);
        src_int[4] = 0; src_int[5] = 0; settle();
        clear_all();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        src_pin[3] = 1; src_pin[9] = 1; settle();
        src_pin[9] = 0; settle();
        rd(A_PPEND, v); chk("R3 bit 9 pending", v, 32'h200);
        src_pin[3] = 0;
        @(negedge clk); @(negedge clk);
        wr(A_PPEND, 32'h208);
        rd(A_PPEND, v); chk("R7 edge beats clear, other bit cleared", v, 32'h8);
        clear_all();
        rd(A_PPEND, v); chk("R6 cleared after collision", v, 32'h0);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        src_int[4] = 1;
        @(negedge clk); @(negedge clk);
        rd(A_IPEND, v); chk("R9 not visible after two edges", v, 32'h0);
        @(negedge clk);
        rd(A_IPEND, v); chk("R9 visible after third edge", v, 32'h10);
        clear_all();
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_IEN, 32'h0000_A5A5);
        rd(A_IEN, v);  chk("R8 int enable readback", v, 32'h0000_A5A5);
        rd(A_PEN, v);  chk("R8 pin enable untouched", v, 32'h0);
        wr(A_PPOL, 32'hFFFF_0000);
        rd(A_PPOL, v); chk("R8 pin edge readback", v, 32'hFFFF_0000);
        rd(A_IPOL, v); chk("R8 int edge untouched", v, 32'h0000_0034);
        wr(A_IMSK, 32'hFFFF_FFFF);
        rd(A_IMSK, v); chk("R8 masked write ignored", v, 32'h0);
        rd(A_IPEND, v); chk("R8 masked write leaves pending", v, 32'h0);
        chk("R8 no wake from masked write", {31'b0, wake_req}, 32'h0);
        wr(A_IEN, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_disabled_and_mask();
        t_partial_clear();
        t_collide();
        t_latency();
        t_map();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule